// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter that sits on a simple 32-bit register bus inside a processor timer block. Software loads a 32-bit down-counter and then enables counting. If the counter is not reloaded before it reaches zero, the block signals expiry. Expiry can raise a one-cycle reset request, a level interrupt, or both. The counter advances once per clock of the fixed-rate timer clock that drives the block.

The counter and enable registers are protected by a lock. A write to either of them is accepted only while the key register holds an exact 32-bit magic value. Writing any other value to the key register locks the block again. Writing zero is the usual way to do it.

The status register has two flags that are cleared by writing one to them. One is a pending flag. The other is a warm-reset cause flag that survives the system (warm) reset triggered by the request. A power-on reset clears everything, including that flag.

Top module: `wdk_top`

## Requirements
- R1: After power-on reset (`por_n` low), every register reads zero. `wdt_rst_req` and `wdt_irq` are low, and the block is locked with counting off.
- R2: A write to the counter or enable register has no effect unless the key register holds exactly 0x0000482E. The key register reads back whatever was last written to it. Any other value, including 0x0001482E or 0, leaves the block locked.
- R3: Register map (byte addresses): counter at 0x14 (32 bits), enable at 0x18, key at 0x1C, status at 0x20. In the enable register, bit 0 is reset-on-expiry, bit 1 is interrupt-on-expiry and bit 2 is count-enable; bits 31:3 read as zero and are discarded on write. Any other address reads zero, and writes to it change nothing.
- R4: While count-enable is set and the counter is nonzero, the counter drops by one on every clock. While count-enable is clear, it holds its value. An accepted bus write to the counter takes priority over that clock's decrement.
- R5: In a cycle where count-enable is set and the counter reads zero, the next edge sets status bit 3 (pending). If reset-on-expiry is set, that same edge also raises `wdt_rst_req` for exactly one cycle. No further request occurs until the counter or enable register is rewritten.
- R6: `wdt_irq` is high exactly while pending is set and interrupt-on-expiry is set. An expiry with reset-on-expiry clear produces no reset request.
- R7: If count-enable and reset-on-expiry are set and the counter is loaded with 0, `wdt_rst_req` is high in the cycle after the edge that follows the write (a forced restart).
- R8: Status bit 4 (warm cause) is set together with every reset request. Writing 1 to status bit 3 or bit 4 clears that bit, with or without the key. A set in the same cycle wins over the clear.
- R9: A warm reset (`sys_rst_n` low at a clock edge) clears the counter, enable, key, pending flag and request. The warm-cause flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate timer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous warm reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |
| wdt_irq | output | 1 | Level interrupt on expiry |

## Verification
The hardest situation to reach from the ports is a warm-cause flag that must outlive a reset. To get there, the bench first has to arm the counter through the full unlock, clear, load, enable sequence and let it expire. It then pulses `sys_rst_n` and reads status back, expecting only bit 4. The stimulus arranges this by loading zero into an armed counter, which forces expiry at a known edge. The exact-cycle checks on the natural countdown then confirm that the request fires once and does not repeat.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_482E;
    localparam logic [7:0]  OFF_CNT    = 8'h14;
    localparam logic [7:0]  OFF_EN     = 8'h18;
    localparam logic [7:0]  OFF_KEY    = 8'h1C;
    localparam logic [7:0]  OFF_STAT   = 8'h20;
    localparam int          ST_PEND    = 3;
    localparam int          ST_WARM    = 4;

    typedef struct packed {
        logic run;   // bit 2
        logic irq;   // bit 1
        logic rst;   // bit 0
    } en_t;
endpackage

// File: rtl/wdk_decode.sv
module wdk_decode
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [CNT_W-1:0]  cnt_val,
    input  en_t               en_val,
    input  logic [31:0]       key_val,
    input  logic              pend,
    input  logic              warm,
    output logic              wr_cnt,
    output logic              wr_en,
    output logic              wr_key,
    output logic              wr_stat,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    always_comb begin
        wr_cnt  = we && (addr == A_CNT);
        wr_en   = we && (addr == A_EN);
        wr_key  = we && (addr == A_KEY);
        wr_stat = we && (addr == A_STAT);
        rdata   = '0;
        case (addr)
            A_CNT:  rdata = 32'(cnt_val);
            A_EN:   rdata = 32'(en_val);
            A_KEY:  rdata = key_val;
            A_STAT: begin
                rdata[ST_PEND] = pend;
                rdata[ST_WARM] = warm;
            end
            default: rdata = '0;
        endcase
    end

    always_comb begin
        a_onehot_r3: assert ($onehot0({wr_cnt, wr_en, wr_key, wr_stat}));
    end
endmodule

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
    import wdk_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        clr,
    input  logic        wr_key,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] key_q,
    output en_t         en_q,
    output logic        unlocked,
    output logic        en_acc
);
    typedef struct packed {
        logic [31:0] key;
        en_t         en;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        unlocked = (s_q.key == UNLOCK_KEY);
        en_acc   = wr_en && unlocked;
        if (wr_key) s_d.key = wdata;
        if (en_acc) s_d.en  = en_t'(wdata[2:0]);
        if (clr)    s_d     = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign key_q = s_q.key;
    assign en_q  = s_q.en;

    p_locked_en_r2: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked && !clr) |=> $stable(en_q));
    p_warm_clears_key_r9: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (key_q == '0 && en_q == '0));
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             run,
    input  logic             rearm,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = run && (s_q.cnt == '0) && !s_q.fired && !ld && !clr;
        if (ld) begin
            s_d.cnt   = ld_val;
            s_d.fired = 1'b0;
        end else begin
            if (rearm) s_d.fired = 1'b0;
            if (run && s_q.cnt != '0) s_d.cnt = s_q.cnt - CNT_W'(1);
            if (expire) s_d.fired = 1'b1;
        end
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q = s_q.cnt;

    p_dec_r4: assert property (@(posedge clk) disable iff (!por_n)
        (run && !ld && !clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    p_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!run && !ld && !clr) |=> $stable(cnt_q));
    p_load_r4: assert property (@(posedge clk) disable iff (!por_n)
        (ld && !clr) |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/wdk_stat.sv
module wdk_stat (
    input  logic       clk,
    input  logic       por_n,
    input  logic       clr,
    input  logic       expire,
    input  logic       rst_en,
    input  logic       w1c,
    input  logic [1:0] w1c_bits,   // [0]=pending, [1]=warm cause
    output logic       pend_q,
    output logic       warm_q,
    output logic       req_q
);
    typedef struct packed {
        logic pend;
        logic warm;
        logic req;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = expire && rst_en;
        if (w1c && w1c_bits[0]) s_d.pend = 1'b0;
        if (w1c && w1c_bits[1]) s_d.warm = 1'b0;
        if (expire)             s_d.pend = 1'b1;
        if (expire && rst_en)   s_d.warm = 1'b1;
        if (clr) begin
            s_d.pend = 1'b0;
            s_d.req  = 1'b0;
            s_d.warm = s_q.warm;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_q = s_q.pend;
    assign warm_q = s_q.warm;
    assign req_q  = s_q.req;

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
        req_q |=> !req_q);
    p_pend_set_r5: assert property (@(posedge clk) disable iff (!por_n)
        (expire && !clr) |=> pend_q);
    p_warm_with_req_r8: assert property (@(posedge clk) disable iff (!por_n)
        req_q |-> warm_q);
    p_warm_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (warm_q == $past(warm_q)));
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_req,
    output logic              wdt_irq
);
    logic             clr;
    logic             wr_cnt, wr_en, wr_key, wr_stat;
    logic [31:0]      key_q;
    en_t              en_q;
    logic             unlocked, en_acc;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             pend_q, warm_q, req_q;

    assign clr = !sys_rst_n;

    wdk_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .addr(bus_addr), .we(bus_we),
        .cnt_val(cnt_q), .en_val(en_q), .key_val(key_q),
        .pend(pend_q), .warm(warm_q),
        .wr_cnt(wr_cnt), .wr_en(wr_en), .wr_key(wr_key), .wr_stat(wr_stat),
        .rdata(bus_rdata)
    );

    wdk_ctrl u_ctrl (
        .clk(clk), .por_n(por_n), .clr(clr),
        .wr_key(wr_key), .wr_en(wr_en), .wdata(bus_wdata),
        .key_q(key_q), .en_q(en_q), .unlocked(unlocked), .en_acc(en_acc)
    );

    wdk_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .clr(clr),
        .ld(wr_cnt && unlocked), .ld_val(bus_wdata[CNT_W-1:0]),
        .run(en_q.run), .rearm(en_acc),
        .cnt_q(cnt_q), .expire(expire)
    );

    wdk_stat u_stat (
        .clk(clk), .por_n(por_n), .clr(clr),
        .expire(expire), .rst_en(en_q.rst),
        .w1c(wr_stat), .w1c_bits({bus_wdata[ST_WARM], bus_wdata[ST_PEND]}),
        .pend_q(pend_q), .warm_q(warm_q), .req_q(req_q)
    );

    assign wdt_rst_req = req_q;
    assign wdt_irq     = pend_q && en_q.irq;

    p_locked_cnt_r2: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked && !clr && !en_q.run) |=> $stable(cnt_q));
    p_no_req_wo_en_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!en_q.rst) |=> !wdt_rst_req);
endmodule

// File: tb/sim_wdk_top.sv
module sim_wdk_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;
    logic        wdt_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdk_top u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
    );

    localparam logic [7:0] A_CNT = 8'h14, A_EN = 8'h18, A_KEY = 8'h1C, A_ST = 8'h20;
    localparam logic [31:0] KEY = 32'h0000_482E;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // Write then read back the same address; counting stays off throughout.
    localparam vec_t VEC [15] = '{
        '{A_CNT, 32'h0000_1234, 32'h0},          // R2 locked after reset
        '{A_EN,  32'h0000_0007, 32'h0},          // R2 locked
        '{A_KEY, 32'h0000_1234, 32'h0000_1234},  // R2 wrong key reads back
        '{A_CNT, 32'h0000_0055, 32'h0},          // R2 still locked
        '{A_KEY, 32'h0001_482E, 32'h0001_482E},  // R2 full-width compare
        '{A_CNT, 32'h0000_0066, 32'h0},          // R2 still locked
        '{A_KEY, KEY,           KEY},            // R2 unlock
        '{A_CNT, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R3 counter 32 bits
        '{A_EN,  32'hFFFF_FFFA, 32'h0000_0002},  // R3 only bits 2:0 kept
        '{A_CNT, 32'h0000_0010, 32'h0000_0010},  // R2 unlocked write
        '{A_KEY, 32'h0,         32'h0},          // R2 relock
        '{A_CNT, 32'h0000_0099, 32'h0000_0010},  // R2 ignored
        '{A_EN,  32'h0,         32'h0000_0002},  // R2 ignored
        '{8'h24, 32'h0000_FFFF, 32'h0},          // R3 unmapped
        '{A_ST,  32'h0,         32'h0}           // R3 status idle
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Called at a negedge; one write consumes exactly one rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        por_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_reg("R1 cnt", A_CNT, 0);
        chk_reg("R1 en", A_EN, 0);
        chk_reg("R1 key", A_KEY, 0);
        chk_reg("R1 stat", A_ST, 0);
        chk("R1 rst_req", 32'(wdt_rst_req), 0);
        chk("R1 irq", 32'(wdt_irq), 0);

        // Table walk: R2 / R3
        for (int i = 0; i < 15; i++) begin
            wr(VEC[i].addr, VEC[i].data);
            chk_reg($sformatf("R2/R3 vec%0d", i), VEC[i].addr, VEC[i].exp);
        end

        // R4/R5 arming sequence and natural expiry
        wr(A_KEY, KEY);
        wr(A_EN, 0);
        wr(A_CNT, 20);
        wr(A_EN, 5);
        chk_reg("R4 armed", A_CNT, 20);
        idle(3);
        chk_reg("R4 dec", A_CNT, 17);
        wr(A_KEY, 0);
        chk_reg("R4 dec during lock", A_CNT, 16);
        idle(16);
        chk("R5 no early req", 32'(wdt_rst_req), 0);
        chk_reg("R4 at zero", A_CNT, 0);
        idle(1);
        chk("R5 req", 32'(wdt_rst_req), 1);
        chk_reg("R5 stat", A_ST, 32'h18);
        chk("R6 irq off", 32'(wdt_irq), 0);
        idle(1);
        chk("R5 one cycle", 32'(wdt_rst_req), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                idle(1);
                if (wdt_rst_req) seen++;
            end
            chk("R5 no repeat", 32'(seen), 0);
        end

        // R8 W1C without key
        wr(A_ST, 32'h08);
        chk_reg("R8 clear pend", A_ST, 32'h10);
        wr(A_ST, 32'h10);
        chk_reg("R8 clear warm", A_ST, 0);

        // R6 interrupt only
        wr(A_KEY, KEY);
        wr(A_EN, 0);
        wr(A_CNT, 3);
        wr(A_EN, 6);
        idle(3);
        chk("R6 irq before", 32'(wdt_irq), 0);
        idle(1);
        chk("R6 irq", 32'(wdt_irq), 1);
        chk("R6 no req", 32'(wdt_rst_req), 0);
        chk_reg("R6 stat", A_ST, 32'h08);
        wr(A_ST, 32'h08);
        chk("R6 irq cleared", 32'(wdt_irq), 0);

        // R7 forced restart by loading zero
        wr(A_EN, 0);
        wr(A_CNT, 1000);
        wr(A_EN, 5);
        idle(2);
        chk("R7 idle", 32'(wdt_rst_req), 0);
        wr(A_CNT, 0);
        chk("R7 not yet", 32'(wdt_rst_req), 0);
        idle(1);
        chk("R7 req", 32'(wdt_rst_req), 1);
        chk_reg("R8 warm set", A_ST, 32'h18);
        idle(1);
        chk("R7 pulse end", 32'(wdt_rst_req), 0);

        // R9 warm reset keeps only the cause flag
        sys_rst_n = 1'b0;
        idle(1);
        sys_rst_n = 1'b1;
        chk_reg("R9 key", A_KEY, 0);
        chk_reg("R9 en", A_EN, 0);
        chk_reg("R9 cnt", A_CNT, 0);
        chk_reg("R9 stat", A_ST, 32'h10);

        // R4 write priority and stop sequence
        wr(A_KEY, KEY);
        wr(A_CNT, 50);
        wr(A_EN, 5);
        idle(4);
        chk_reg("R4 run", A_CNT, 46);
        wr(A_CNT, 100);
        chk_reg("R4 write wins", A_CNT, 100);
        wr(A_EN, 0);
        chk_reg("R4 stop", A_CNT, 99);
        wr(A_KEY, 0);
        idle(10);
        chk_reg("R4 held", A_CNT, 99);
        chk("R4 no req", 32'(wdt_rst_req), 0);

        // R1 power-on reset clears the warm flag
        por_n = 1'b0;
        idle(1);
        por_n = 1'b1;
        idle(1);
        chk_reg("R1 por stat", A_ST, 0);
        chk_reg("R1 por cnt", A_CNT, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule